// File: doc/BRIEF.md
# Nine-Bit Three-Wire Serial Display Framer

This block takes display bytes one per handshake beat, each tagged as a command or as data, and sends them out on a three-wire serial link made of chip select, serial clock and a single data line. Every byte becomes a 9-bit frame. The tag bit is sent first and the byte follows it. Frames are packed into the serial stream with no missing bit positions, so a display controller that samples on the rising clock edge sees one continuous bitstream. There is no separate command/data pin.

A beat marked as the end of a burst closes the burst. At that point the block works out how far the stream is from a whole byte. It appends whole filler command frames until the total bit count is a multiple of eight, and only then releases chip select. The serial clock rate is set by a divider parameter. The divider is forced up when needed so that the clock period never falls below 100 ns at the stated system clock frequency.

Top module: `spi9_framer`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0 and `in_ready` is 1.
- R2: Each accepted beat is sent as a 9-bit frame. The first bit is the tag (0 = command, 1 = data) and the 8 payload bits follow, most significant first.
- R3: The serial clock idles low whenever chip select is high. `spi_mosi` does not change while `spi_sclk` is high, so the receiver samples it on the rising edge.
- R4: Within a burst, `spi_cs_n` stays low across frames, including while the input stalls between beats. Successive frames follow each other in the bitstream with no extra bits between them.
- R5: When the flush beat is accepted with N frames in the burst, the block appends (8 − N mod 8) mod 8 filler frames. Each filler frame has tag 0 and payload FILL_CMD (default 8'h5C).
- R6: A burst whose frame count is a multiple of 8 gets no filler frames. For example, 8 frames give exactly 72 clocked bits.
- R7: `spi_cs_n` rises only after the last bit of the last frame, with the number of rising clock edges since it fell a multiple of 8. It stays high between bursts, and the next burst counts its alignment from zero.
- R8: `in_ready` is low while a frame is being shifted out, and from the acceptance of a flush beat until `spi_cs_n` is released.
- R9: Each half period of `spi_sclk` lasts EFF_HALF system cycles. EFF_HALF is HALF_DIV raised to at least ceil(MIN_SCLK_NS · SYS_MHZ / 2000). At the default 100 MHz this gives a high phase of 5 cycles and a period of at least 100 ns, even when HALF_DIV is set lower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat can be accepted this cycle |
| in_byte | input | 8 | Byte to send |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_flush | input | 1 | This beat is the last of its burst; pad after it |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |

## Verification
Bursts of 1, 3, 9 and 16 frames need 7, 5, 7 and 0 fillers. Together with an 8-frame all-data burst, they tell the padding arithmetic apart from a fixed or missing pad. A mixed command/data burst with alternating bit patterns exposes a wrong tag polarity or a wrong bit order. A burst with long stalls between beats shows whether chip select or stray bits leak into the gaps. A second instance with a divider set below the minimum must track the first one cycle for cycle, which shows that the period clamp works.

// File: rtl/spi9_pkg.sv
package spi9_pkg;

    localparam int FRAME_BITS = 9;

    typedef struct packed {
        logic       is_data;
        logic [7:0] payload;
    } frame_t;

    function automatic frame_t make_frame(input logic d, input logic [7:0] b);
        frame_t f;
        f.is_data = d;
        f.payload = b;
        return f;
    endfunction

    // smallest half period, in system cycles, that keeps the full period >= min_ns
    function automatic int min_half(input int sys_mhz, input int min_ns);
        int h;
        h = (min_ns * sys_mhz + 1999) / 2000;
        return (h < 1) ? 1 : h;
    endfunction

    // filler frames needed to bring a frame-count phase back to a byte boundary
    function automatic logic [2:0] fill_count(input logic [2:0] phase);
        return 3'(3'd0 - phase);
    endfunction

endpackage

// File: rtl/spi9_shifter.sv
module spi9_shifter
    import spi9_pkg::*;
#(
    parameter int HALF = 5
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame,
    output logic   busy,
    output logic   sclk,
    output logic   mosi
);

    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HW-1:0] HLAST = HW'(HALF - 1);
    localparam logic [3:0] BLAST = 4'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [3:0]            bitidx;
    logic [HW-1:0]         hcnt;
    logic                  hi;
    logic                  half_end;

    assign half_end = (hcnt == HLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            shreg  <= '0;
            bitidx <= '0;
            hcnt   <= '0;
            hi     <= 1'b0;
        end else if (load) begin
            busy   <= 1'b1;
            shreg  <= frame;
            bitidx <= '0;
            hcnt   <= '0;
            hi     <= 1'b0;
        end else if (busy) begin
            if (half_end) begin
                hcnt <= '0;
                if (!hi) begin
                    hi <= 1'b1;
                end else begin
                    hi     <= 1'b0;
                    shreg  <= {shreg[FRAME_BITS-2:0], 1'b0};
                    bitidx <= bitidx + 4'd1;
                    if (bitidx == BLAST)
                        busy <= 1'b0;
                end
            end else begin
                hcnt <= hcnt + HW'(1);
            end
        end
    end

    assign sclk = busy & hi;
    assign mosi = busy & shreg[FRAME_BITS-1];

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy); // R8

endmodule

// File: rtl/spi9_pad_ctrl.sv
module spi9_pad_ctrl
    import spi9_pkg::*;
#(
    parameter logic [7:0] FILL_CMD = 8'h5C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic       in_is_data,
    input  logic       in_flush,
    input  logic       sh_busy,
    output logic       load,
    output frame_t     frame,
    output logic       cs_n
);

    logic       pad_mode;
    logic [2:0] phase;
    logic [2:0] pad_left;
    logic       accept;
    logic       pad_load;
    logic       release_cs;
    logic [2:0] next_phase;

    assign in_ready   = !sh_busy && !pad_mode;
    assign accept     = in_valid && in_ready;
    assign pad_load   = pad_mode && !sh_busy && (pad_left != 3'd0);
    assign release_cs = pad_mode && !sh_busy && (pad_left == 3'd0);
    assign load       = accept || pad_load;
    assign frame      = accept ? make_frame(in_is_data, in_byte)
                               : make_frame(1'b0, FILL_CMD);
    assign next_phase = phase + 3'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_mode <= 1'b0;
            phase    <= '0;
            pad_left <= '0;
            cs_n     <= 1'b1;
        end else if (accept) begin
            cs_n  <= 1'b0;
            phase <= next_phase;
            if (in_flush) begin
                pad_mode <= 1'b1;
                pad_left <= fill_count(next_phase);
            end
        end else if (pad_load) begin
            pad_left <= pad_left - 3'd1;
            phase    <= next_phase;
        end else if (release_cs) begin
            cs_n     <= 1'b1;
            pad_mode <= 1'b0;
            phase    <= '0;
        end
    end

    AST_PHASE_ZERO_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        release_cs |-> (phase == 3'd0)); // R5

    AST_NO_ACCEPT_IN_PAD: assert property (@(posedge clk) disable iff (rst)
        pad_mode |-> !accept); // R8

endmodule

// File: rtl/spi9_framer.sv
module spi9_framer
    import spi9_pkg::*;
#(
    parameter int         SYS_MHZ     = 100,
    parameter int         MIN_SCLK_NS = 100,
    parameter int         HALF_DIV    = 5,
    parameter logic [7:0] FILL_CMD    = 8'h5C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic       in_is_data,
    input  logic       in_flush,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi
);

    localparam int MIN_HALF = min_half(SYS_MHZ, MIN_SCLK_NS);
    localparam int EFF_HALF = (HALF_DIV < MIN_HALF) ? MIN_HALF : HALF_DIV;

    logic   sh_busy;
    logic   sh_load;
    frame_t sh_frame;

    spi9_pad_ctrl #(.FILL_CMD(FILL_CMD)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_byte    (in_byte),
        .in_is_data (in_is_data),
        .in_flush   (in_flush),
        .sh_busy    (sh_busy),
        .load       (sh_load),
        .frame      (sh_frame),
        .cs_n       (spi_cs_n)
    );

    spi9_shifter #(.HALF(EFF_HALF)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (sh_load),
        .frame (sh_frame),
        .busy  (sh_busy),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi)
    );

    // rising clock edges since chip select fell, modulo one byte
    logic       sclk_q;
    logic [2:0] edge_mod;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            edge_mod <= '0;
        end else begin
            sclk_q <= spi_sclk;
            if (spi_cs_n)
                edge_mod <= '0;
            else if (spi_sclk && !sclk_q)
                edge_mod <= edge_mod + 3'd1;
        end
    end

    AST_CS_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> (edge_mod == 3'd0)); // R7

    AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !spi_cs_n); // R4

    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R3

    AST_READY_LOW_SHIFTING: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !in_ready); // R8

endmodule

// File: tb/sim_spi9_framer.sv
module sim_spi9_framer;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_is_data = 1'b0;
    logic       in_flush = 1'b0;
    logic       rdy0, cs0, sclk0, mosi0;
    logic       rdy1, cs1, sclk1, mosi1;

    spi9_framer #(.HALF_DIV(5)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy0),
        .in_byte(in_byte), .in_is_data(in_is_data), .in_flush(in_flush),
        .spi_cs_n(cs0), .spi_sclk(sclk0), .spi_mosi(mosi0));

    // divider set too low: must be clamped to the same rate as u0
    spi9_framer #(.HALF_DIV(2)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy1),
        .in_byte(in_byte), .in_is_data(in_is_data), .in_flush(in_flush),
        .spi_cs_n(cs1), .spi_sclk(sclk1), .spi_mosi(mosi1));

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard: {is_filler, tag, payload}
    logic [9:0] expq[$];
    int burst_frames = 0;

    task automatic send(input logic [7:0] b, input logic d, input logic f);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; in_is_data = d; in_flush = f;
        while (!rdy0) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_flush = 1'b0;
        expq.push_back({1'b0, d, b});
        burst_frames++;
        if (f) begin
            for (int i = 0; i < (8 - burst_frames % 8) % 8; i++)
                expq.push_back({1'b1, 1'b0, 8'h5C});
            burst_frames = 0;
        end
    endtask

    int pad_rdy_err = 0;
    task automatic wait_release();
        @(negedge clk);
        while (!cs0) begin
            if (rdy0) pad_rdy_err++;
            @(negedge clk);
        end
    endtask

    // monitor: collect bits on rising serial clock
    logic [8:0] shbuf = '0;
    int nbits = 0;
    int bits_burst = 0;
    int last_burst_bits = 0;

    always @(posedge sclk0) begin
        logic [9:0] e;
        shbuf = {shbuf[7:0], mosi0};
        nbits++;
        bits_burst++;
        if (nbits == 9) begin
            nbits = 0;
            if (expq.size() == 0) begin
                check(1'b0, "R2 unexpected frame", int'(shbuf), 0);
            end else begin
                e = expq.pop_front();
                if (e[9]) check(shbuf == e[8:0], "R5 filler frame", int'(shbuf), int'(e[8:0]));
                else      check(shbuf == e[8:0], "R2 frame", int'(shbuf), int'(e[8:0]));
            end
        end
    end

    always @(posedge cs0) begin
        if (!rst) begin
            check(nbits == 0 && bits_burst % 8 == 0, "R7 release on byte boundary", bits_burst, 0);
            check(expq.size() == 0, "R4 burst complete at release", expq.size(), 0);
            last_burst_bits = bits_burst;
            bits_burst = 0;
        end
    end

    // sampled away from the active edge
    int r3_err = 0, r9_err = 0, r9_match_err = 0, r8_err = 0, hi_len = 0, hi_cnt = 0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (sclk0 && prev_sclk && mosi0 != prev_mosi) r3_err++;
            if (cs0 && sclk0) r3_err++;
            if (sclk0 && rdy0) r8_err++;
            if (sclk0) hi_len++;
            else begin
                if (prev_sclk) begin
                    if (hi_len != 5) r9_err++;
                    hi_cnt++;
                end
                hi_len = 0;
            end
            if ({cs1, sclk1, mosi1, rdy1} != {cs0, sclk0, mosi0, rdy0}) r9_match_err++;
            prev_sclk = sclk0;
            prev_mosi = mosi0;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(cs0 == 1 && sclk0 == 0 && mosi0 == 0 && rdy0 == 1, "R1 in reset",
              int'({cs0, sclk0, mosi0, rdy0}), 'b1001);
        rst = 1'b0;
        @(negedge clk);
        check(cs0 == 1 && sclk0 == 0 && mosi0 == 0 && rdy0 == 1, "R1 after reset",
              int'({cs0, sclk0, mosi0, rdy0}), 'b1001);

        // burst A: lone command, 7 fillers (R5)
        send(8'hAE, 1'b0, 1'b1);
        wait_release();
        check(last_burst_bits == 72, "R5 one frame padded to 72 bits", last_burst_bits, 72);

        // burst B: command + two data, 5 fillers (R2, R5)
        send(8'h15, 1'b0, 1'b0);
        send(8'h1C, 1'b1, 1'b0);
        send(8'h5B, 1'b1, 1'b1);
        wait_release();
        check(last_burst_bits == 72, "R5 three frames padded to 72 bits", last_burst_bits, 72);

        // burst C: eight data frames, no filler (R6)
        for (int i = 0; i < 8; i++)
            send(8'(8'hA5 ^ (i * 37)), 1'b1, i == 7);
        wait_release();
        check(last_burst_bits == 72, "R6 eight frames, no filler", last_burst_bits, 72);

        // burst D: stalls between beats, chip select must hold (R4)
        for (int i = 0; i < 5; i++) begin
            send(8'(8'h80 >> i), i[0], i == 4);
            if (i != 4) begin
                repeat (30) @(negedge clk);
                check(cs0 == 0, "R4 cs held across stall", int'(cs0), 0);
            end
        end
        wait_release();
        check(last_burst_bits == 72, "R5 five frames padded", last_burst_bits, 72);

        // burst E: 16-byte command transfer, no filler (R6)
        send(8'hB3, 1'b0, 1'b0);
        for (int i = 0; i < 15; i++)
            send(8'(i * 17 + 3), 1'b1, i == 14);
        wait_release();
        check(last_burst_bits == 144, "R6 sixteen frames, no filler", last_burst_bits, 144);

        // burst F: nine frames, 7 fillers; alignment restarts per burst (R7)
        for (int i = 0; i < 9; i++)
            send(8'(8'hFF - i), i != 0, i == 8);
        wait_release();
        check(last_burst_bits == 144, "R7 nine frames padded to 144", last_burst_bits, 144);

        repeat (20) @(negedge clk);
        check(cs0 == 1 && sclk0 == 0, "R3 idle between bursts", int'({cs0, sclk0}), 'b10);
        check(r3_err == 0, "R3 mosi stable while clock high", r3_err, 0);
        check(r8_err == 0, "R8 ready low while shifting", r8_err, 0);
        check(pad_rdy_err == 0, "R8 ready low while padding", pad_rdy_err, 0);
        check(r9_err == 0 && hi_cnt > 0, "R9 clock high phase of 5 cycles", r9_err, 0);
        check(r9_match_err == 0, "R9 low divider clamped", r9_match_err, 0);
        summary();
        $finish;
    end

endmodule